// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM

A small synchronous static memory that takes a read or a write command on every rising clock edge, with no idle cycle needed when the bus changes direction. A configuration input picks one of two output timings. In flow-through timing, read data comes out one edge after the address. In pipelined timing, read data passes through an output register and comes out two edges after the address. Write data is accepted late, in the same slot where read data would have appeared. Because of this, a write's address and its data are on the shared bus in different cycles, and any mix of reads and writes keeps the data bus busy every cycle.

Each word is made of 9-bit byte lanes, and each lane has its own write enable. Three chip enables must all be high to select the device, which lets several devices share one bus for depth expansion. An output enable and a sleep input act on the output drive at once, without waiting for a clock. A pipelined read that targets a word whose late write is being committed on the same edge gets the new bytes forwarded into its result. Every read therefore returns the contents in program order.

Top module: `zt_sram`

## Requirements
- R1: A command is accepted only on an edge where `ce1`, `ce2` and `ce3` are all 1 and `sleep` is 0. A deselected edge writes nothing and leaves its data slot undriven (`dq_oe` = 0).
- R2: With `flow_mode` = 0 (pipelined), a read accepted at edge n drives the word with `dq_oe` = 1 between edges n+1 and n+2.
- R3: With `flow_mode` = 1 (flow-through), a read accepted at edge n drives the word with `dq_oe` = 1 between edges n and n+1.
- R4: The data of a write accepted at edge n is sampled from `dq_in` at edge n+1 in flow-through mode and at edge n+2 in pipelined mode.
- R5: Byte lane i is bits [9i+8:9i] of the data bus. Only lanes with `byte_en[i]` = 1 are updated by a write; the other lanes keep their old value.
- R6: A read accepted on the edge right after a write to the same address returns the newly written lanes merged with the old contents of the unwritten lanes.
- R7: Reads and writes may alternate on consecutive edges with no idle cycle, and every read returns the contents left by all earlier accepted writes.
- R8: While `oe` = 0, `dq_oe` is 0 at once, and the command stream is not disturbed.
- R9: While `sleep` = 1, new commands are ignored and `dq_oe` is 0. Writes accepted before sleep still take their data and complete.
- R10: While `rst_n` = 0 and after its release, no slot is driven until a read is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of the command pipeline |
| flow_mode | input | 1 | 1 = flow-through timing, 0 = pipelined; change only in reset |
| addr | input | ADDR_W | Word address, sampled on the edge |
| wr_rd | input | 1 | 1 = write command, 0 = read command |
| byte_en | input | BYTES | Per-lane write enables, sampled with the command |
| ce1 | input | 1 | Chip enable, active high |
| ce2 | input | 1 | Chip enable, active high |
| ce3 | input | 1 | Chip enable, active high |
| oe | input | 1 | Asynchronous output enable, active high |
| sleep | input | 1 | Power-down request, active high |
| dq_in | input | BYTES*BYTE_W | Write data, inbound half of the data bus |
| dq_out | output | BYTES*BYTE_W | Read data, outbound half of the data bus (0 when not driven) |
| dq_oe | output | 1 | High when the device drives the data bus |

## Verification
The sharpest corner is a pipelined read issued one edge after a write to the same word. A design without forwarding returns the stale word, and one that forwards whole words instead of lanes corrupts the lanes that were not written. Back-to-back sweeps over every address in both timings expose an output slot that is one cycle off, which shows up as data from the wrong neighbour or as the bus driven in an empty slot. Deselect, output-enable and sleep windows are checked for a bus that is driven when it should be idle. Each of these cases also checks for a write that is dropped or wrongly applied, which shows up as wrong data on a later read-back.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;

  typedef enum logic {
    OP_READ  = 1'b0,
    OP_WRITE = 1'b1
  } op_e;

  // all three enables must be high for the device to respond
  function automatic logic chips_selected(input logic [2:0] ce);
    return ce[0] & ce[1] & ce[2];
  endfunction

endpackage

// File: rtl/zt_cmd_pipe.sv
module zt_cmd_pipe
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int BYTES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flow_mode,
  input  logic              take,
  input  op_e               op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTES-1:0]  ben,
  output logic              s1_rd,
  output logic [ADDR_W-1:0] s1_addr,
  output logic              commit_vld,
  output logic [ADDR_W-1:0] commit_addr,
  output logic [BYTES-1:0]  commit_ben
);

  typedef struct packed {
    logic              vld;
    op_e               op;
    logic [ADDR_W-1:0] addr;
    logic [BYTES-1:0]  ben;
  } slot_t;

  slot_t st1, st2, st_in;

  always_comb begin
    st_in.vld  = take;
    st_in.op   = op;
    st_in.addr = addr;
    st_in.ben  = ben;
  end

  // first stage holds the command just taken, second holds the one before
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st1 <= '0;
      st2 <= '0;
    end else begin
      st1 <= st_in;
      st2 <= st1;
    end
  end

  assign s1_rd   = st1.vld && (st1.op == OP_READ);
  assign s1_addr = st1.addr;

  // the write whose data is on dq_in in this cycle
  slot_t wslot;
  assign wslot       = flow_mode ? st1 : st2;
  assign commit_vld  = wslot.vld && (wslot.op == OP_WRITE);
  assign commit_addr = wslot.addr;
  assign commit_ben  = wslot.ben;

endmodule

// File: rtl/zt_array.sv
module zt_array #(
  parameter int ADDR_W = 6,
  parameter int BYTES  = 2,
  parameter int BYTE_W = 9
) (
  input  logic                    clk,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [BYTES-1:0]        wr_ben,
  input  logic [BYTES*BYTE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0]       rd_addr,
  output logic [BYTES*BYTE_W-1:0] rd_data
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    logic [BYTE_W-1:0] cells [DEPTH];

    // self-timed write: the edge itself commits the lane
    always_ff @(posedge clk) begin
      if (wr_en && wr_ben[g])
        cells[wr_addr] <= wr_data[g*BYTE_W +: BYTE_W];
    end

    assign rd_data[g*BYTE_W +: BYTE_W] = cells[rd_addr];
  end

endmodule

// File: rtl/zt_out_stage.sv
module zt_out_stage #(
  parameter int BYTES  = 2,
  parameter int BYTE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    flow_mode,
  input  logic                    oe,
  input  logic                    sleep,
  input  logic                    s1_rd,
  input  logic [BYTES*BYTE_W-1:0] arr_data,
  input  logic                    fwd_hit,
  input  logic [BYTES-1:0]        fwd_ben,
  input  logic [BYTES*BYTE_W-1:0] fwd_data,
  output logic                    rd_slot,
  output logic [BYTES*BYTE_W-1:0] dq_out,
  output logic                    dq_oe
);

  localparam int DW = BYTES * BYTE_W;

  // replace the enabled lanes of old_w with those of new_w
  function automatic logic [DW-1:0] lane_merge(input logic [DW-1:0] old_w,
                                               input logic [DW-1:0] new_w,
                                               input logic [BYTES-1:0] sel);
    logic [DW-1:0] r;
    r = old_w;
    for (int i = 0; i < BYTES; i++)
      if (sel[i]) r[i*BYTE_W +: BYTE_W] = new_w[i*BYTE_W +: BYTE_W];
    return r;
  endfunction

  logic          q_vld;
  logic [DW-1:0] q_data;
  logic [DW-1:0] fwd_word;

  assign fwd_word = fwd_hit ? lane_merge(arr_data, fwd_data, fwd_ben) : arr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_vld  <= 1'b0;
      q_data <= '0;
    end else begin
      q_vld  <= s1_rd && !flow_mode;
      q_data <= fwd_word;
    end
  end

  logic [DW-1:0] slot_data;
  assign rd_slot   = flow_mode ? s1_rd : q_vld;
  assign slot_data = flow_mode ? arr_data : q_data;
  assign dq_oe     = rd_slot && oe && !sleep;
  assign dq_out    = dq_oe ? slot_data : '0;

endmodule

// File: rtl/zt_sram.sv
module zt_sram
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int BYTES  = 2,
  parameter int BYTE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    flow_mode,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    wr_rd,
  input  logic [BYTES-1:0]        byte_en,
  input  logic                    ce1,
  input  logic                    ce2,
  input  logic                    ce3,
  input  logic                    oe,
  input  logic                    sleep,
  input  logic [BYTES*BYTE_W-1:0] dq_in,
  output logic [BYTES*BYTE_W-1:0] dq_out,
  output logic                    dq_oe
);

  localparam int DW = BYTES * BYTE_W;

  logic              take;
  logic              cap_rd;
  logic              cap_wr;
  op_e               op;
  logic              s1_rd;
  logic [ADDR_W-1:0] s1_addr;
  logic              commit_vld;
  logic [ADDR_W-1:0] commit_addr;
  logic [BYTES-1:0]  commit_ben;
  logic [DW-1:0]     arr_data;
  logic              fwd_hit;
  logic              rd_slot;

  assign take   = chips_selected({ce3, ce2, ce1}) && !sleep;
  assign op     = wr_rd ? OP_WRITE : OP_READ;
  assign cap_rd = take && (op == OP_READ);
  assign cap_wr = take && (op == OP_WRITE);

  zt_cmd_pipe #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_pipe (
    .clk         (clk),
    .rst_n       (rst_n),
    .flow_mode   (flow_mode),
    .take        (take),
    .op          (op),
    .addr        (addr),
    .ben         (byte_en),
    .s1_rd       (s1_rd),
    .s1_addr     (s1_addr),
    .commit_vld  (commit_vld),
    .commit_addr (commit_addr),
    .commit_ben  (commit_ben)
  );

  zt_array #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(BYTE_W)) u_array (
    .clk     (clk),
    .wr_en   (commit_vld),
    .wr_addr (commit_addr),
    .wr_ben  (commit_ben),
    .wr_data (dq_in),
    .rd_addr (s1_addr),
    .rd_data (arr_data)
  );

  // a pipelined read registers on the same edge the older write commits
  assign fwd_hit = commit_vld && (commit_addr == s1_addr);

  zt_out_stage #(.BYTES(BYTES), .BYTE_W(BYTE_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .flow_mode (flow_mode),
    .oe        (oe),
    .sleep     (sleep),
    .s1_rd     (s1_rd),
    .arr_data  (arr_data),
    .fwd_hit   (fwd_hit),
    .fwd_ben   (commit_ben),
    .fwd_data  (dq_in),
    .rd_slot   (rd_slot),
    .dq_out    (dq_out),
    .dq_oe     (dq_oe)
  );

endmodule

// File: rtl/zt_sram_chk.sv
module zt_sram_chk (
  input logic clk,
  input logic rst_n,
  input logic flow_mode,
  input logic oe,
  input logic sleep,
  input logic take,
  input logic cap_rd,
  input logic cap_wr,
  input logic commit_vld,
  input logic rd_slot,
  input logic dq_oe
);

  AST_DESEL_FLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && flow_mode) |=> !rd_slot);                           // R1
  AST_DESEL_PIPE: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && !flow_mode) |-> ##2 !rd_slot);                      // R1
  AST_PIPE_READ_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_rd && !flow_mode) |-> ##2 rd_slot);                      // R2
  AST_FLOW_READ_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_rd && flow_mode) |=> rd_slot);                           // R3
  AST_FLOW_LATE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_wr && flow_mode) |=> commit_vld);                        // R4
  AST_PIPE_LATE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_wr && !flow_mode) |-> ##2 commit_vld);                   // R4
  AST_OE_OVERRIDE: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> !dq_oe);                                              // R8
  AST_SLEEP_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !dq_oe);                                            // R9

endmodule

bind zt_sram zt_sram_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .flow_mode  (flow_mode),
  .oe         (oe),
  .sleep      (sleep),
  .take       (take),
  .cap_rd     (cap_rd),
  .cap_wr     (cap_wr),
  .commit_vld (commit_vld),
  .rd_slot    (rd_slot),
  .dq_oe      (dq_oe)
);

// File: tb/zt_sram_bench.sv
`timescale 1ns/1ps
module zt_sram_bench;

  localparam int AW = 6;
  localparam int NB = 2;
  localparam int BW = 9;
  localparam int DW = NB * BW;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          flow_mode = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          wr_rd = 1'b0;
  logic [NB-1:0] byte_en = '0;
  logic          ce1 = 1'b0, ce2 = 1'b0, ce3 = 1'b0;
  logic          oe = 1'b1;
  logic          sleep = 1'b0;
  logic [DW-1:0] dq_in = '0;
  logic [DW-1:0] dq_out;
  logic          dq_oe;

  always #5 clk = ~clk;

  zt_sram #(.ADDR_W(AW), .BYTES(NB), .BYTE_W(BW)) u_zt_sram (
    .clk(clk), .rst_n(rst_n), .flow_mode(flow_mode), .addr(addr),
    .wr_rd(wr_rd), .byte_en(byte_en), .ce1(ce1), .ce2(ce2), .ce3(ce3),
    .oe(oe), .sleep(sleep), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [DW-1:0] model [DEPTH];
  bit            ev [16];
  logic [DW-1:0] ed [16];
  string         et [16];
  logic [DW-1:0] wd [16];
  int            edge_n = 0;

  function automatic logic [DW-1:0] merge_model(input logic [DW-1:0] o,
                                                input logic [DW-1:0] n,
                                                input logic [NB-1:0] be);
    logic [DW-1:0] mask = '0;
    for (int i = 0; i < NB; i++)
      if (be[i]) mask = mask | (DW'((1 << BW) - 1) << (BW * i));
    return (o & ~mask) | (n & mask);
  endfunction

  function automatic logic [DW-1:0] pat(input int a, input int k);
    return DW'((a * 37 + k * 911 + 5) % (1 << DW));
  endfunction

  task automatic clear_slots();
    for (int i = 0; i < 16; i++) begin
      ev[i] = 0; ed[i] = '0; wd[i] = '0; et[i] = "";
    end
  endtask

  // one edge: check the slot that ends now, then drive the next command
  task automatic step(input logic [2:0] ce, input logic we, input int a,
                      input logic [NB-1:0] be, input logic [DW-1:0] d,
                      input logic oe_v, input logic sl_v, input string tag);
    int m;
    int n2;
    logic exp_oe;
    @(negedge clk);
    m = edge_n % 16;
    exp_oe = ev[m] && oe && !sleep;
    checks++;
    if (dq_oe !== exp_oe || (exp_oe && dq_out !== ed[m])) begin
      errors++;
      $display("FAIL %s edge %0d: dq_oe=%0b dq_out=%h expected dq_oe=%0b dq_out=%h",
               ev[m] ? et[m] : tag, edge_n, dq_oe, dq_out, exp_oe, ed[m]);
    end
    ev[m] = 0;
    dq_in = wd[m];
    wd[m] = '0;
    {ce3, ce2, ce1} = ce;
    wr_rd = we; addr = AW'(a); byte_en = be; oe = oe_v; sleep = sl_v;
    if (ce == 3'b111 && !sl_v) begin
      n2 = (edge_n + (flow_mode ? 1 : 2)) % 16;
      if (we) begin
        model[a] = merge_model(model[a], d, be);
        wd[n2] = d;
      end else begin
        ev[n2] = 1; ed[n2] = model[a]; et[n2] = tag;
      end
    end
    edge_n++;
  endtask

  task automatic wr(input int a, input logic [NB-1:0] be, input logic [DW-1:0] d, input string tag);
    step(3'b111, 1'b1, a, be, d, 1'b1, 1'b0, tag);
  endtask
  task automatic rd(input int a, input string tag);
    step(3'b111, 1'b0, a, '0, '0, 1'b1, 1'b0, tag);
  endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(3'b000, 1'b0, 0, '0, '0, 1'b1, 1'b0, "R1");
  endtask

  task automatic do_reset(input logic fm);
    @(negedge clk);
    rst_n = 1'b0; flow_mode = fm;
    {ce3, ce2, ce1} = 3'b000; oe = 1'b1; sleep = 1'b0; dq_in = '0;
    clear_slots();
    repeat (3) @(negedge clk);
    checks++;
    if (dq_oe !== 1'b0) begin
      errors++;
      $display("FAIL R10 in reset: dq_oe=%0b expected 0", dq_oe);
    end
    rst_n = 1'b1;
    edge_n = 0;
  endtask

  task automatic run_mode(input logic fm);
    string rtag;
    rtag = fm ? "R3" : "R2";
    do_reset(fm);
    idle(2);                                             // R10 quiet after release
    for (int a = 0; a < DEPTH; a++) wr(a, 2'b11, pat(a, 0), "R4");
    for (int a = 0; a < DEPTH; a++) rd(a, rtag);         // full sweep, back to back
    // alternating: write then same-address read (forwarding) then neighbour read
    for (int a = 0; a < DEPTH; a++) begin
      wr(a, 2'b11, pat(a, 1), "R7");
      rd(a, "R6");
      rd((a + 1) % DEPTH, "R7");
    end
    // partial writes with read right after: every lane-enable pattern
    for (int be = 0; be < 4; be++) begin
      wr(10 + be, 2'(be), pat(be, 7), "R5");
      rd(10 + be, "R5");
      wr(20 + be, 2'(be), pat(be, 9), "R5");
      idle(1);
      rd(20 + be, "R5");
    end
    // deselect: every non-selecting enable combination carries a write
    for (int c = 0; c < 7; c++) begin
      step(3'(c), 1'b1, 5, 2'b11, pat(99, c), 1'b1, 1'b0, "R1");
      rd(5, "R1");
    end
    // output enable override on reads
    step(3'b111, 1'b0, 3, '0, '0, 1'b0, 1'b0, "R8");
    step(3'b111, 1'b0, 4, '0, '0, 1'b0, 1'b0, "R8");
    step(3'b111, 1'b0, 4, '0, '0, 1'b1, 1'b0, "R8");
    idle(3);
    // sleep: pending write finishes, new commands ignored
    wr(7, 2'b11, pat(7, 5), "R9");
    step(3'b111, 1'b1, 8, 2'b11, pat(8, 5), 1'b1, 1'b1, "R9");
    step(3'b111, 1'b0, 7, '0, '0, 1'b1, 1'b1, "R9");
    step(3'b111, 1'b0, 7, '0, '0, 1'b1, 1'b1, "R9");
    rd(7, "R9");
    rd(8, "R9");
    idle(4);
  endtask

  initial begin
    clear_slots();
    for (int a = 0; a < DEPTH; a++) model[a] = '0;
    run_mode(1'b0);
    run_mode(1'b1);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule